// File: doc/BRIEF.md
# Accumulator Processor with Index Register

A compact multi-cycle stored-program processor built around a single 16-bit accumulator and a 16-bit index register. It fetches each instruction from one synchronous memory, then decodes and executes it. The memory interface has a registered address, a write strobe with its write data, and a read-data input that is valid one cycle after the address. The sequencing keeps a program counter, an address latch, a data latch and an instruction latch. Every memory transfer passes through these latches.

The instruction set covers the following:
- loading a constant into either register
- direct, indirect and indexed loads into the accumulator
- store and add
- increment and decrement of a selectable register
- an equality compare with jumps taken on its result, and an unconditional jump
- a character output port with a one-cycle strobe
- a halt that parks the processor until reset

Top module: `acc_cpu`

## Requirements
- R1: Fetch is sequenced as address-latch-from-PC, then PC increment while memory reads, then data latch, then instruction latch, then execute. With a constant-load instruction at address 0, `mem_addr` stays 0 for the first five rising edges after reset is released and shows 1 after the sixth.
- R2: An instruction word holds an opcode in bits 15:12, a register select in bit 11 (0 = accumulator, 1 = index) and an operand in bits 10:0. Opcode 1 loads the zero-extended operand into the accumulator, and opcode 2 loads it into the index register.
- R3: Opcode 3 loads the accumulator with the memory word at the operand address.
- R4: Opcode 4 reads the word at the operand address. It uses the low 11 bits of that word as the address of the value loaded into the accumulator.
- R5: Opcode 5 loads the accumulator from address (operand + index register), truncated to 11 bits.
- R6: Opcode 6 writes the accumulator to the operand address with `mem_we` high for exactly one cycle. Opcode 7 adds the word at the operand address to the accumulator.
- R7: Opcode 8 adds 1 and opcode 9 subtracts 1. The register changed is chosen by bit 11, and the other register is left untouched.
- R8: All arithmetic on the accumulator and the index register wraps modulo 2^16.
- R9: Opcode 10 sets the flag when the accumulator equals the word at the operand address, and clears it otherwise. Opcode 11 jumps to the operand when the flag is set. Opcode 12 jumps when the flag is clear. Opcode 13 always jumps.
- R10: Opcode 14 drives the low 8 bits of the accumulator on `out_char` with `out_valid` high for exactly one cycle.
- R11: Opcode 15 raises `halted`. It then stays high until reset, with no further memory writes, no output strobes and no change of `mem_addr`.
- R12: While reset is high, `halted`, `mem_we` and `out_valid` are low and `mem_addr` is 0. PC, accumulator, index register and flag are cleared.
- R13: Opcode 0 is a no-operation: it changes no register, writes no memory and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 11 | Registered memory address (address latch) |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid one cycle after `mem_addr` |
| out_char | output | 8 | Output character |
| out_valid | output | 1 | One-cycle strobe qualifying `out_char` |
| halted | output | 1 | High once the halt opcode has executed |

## Verification
Two things meet at instruction boundaries. A store commits its write in the last cycle of the instruction, and the next instruction's fetch puts a fresh address on the memory in the cycle right after. An increment of the index register is likewise followed at once by an indexed load that must use the new value. The directed programs place these pairs back to back: a store then a reload, index updates then indexed loads, and a compare then the branch that consumes its flag. Each is judged by the words found in memory afterwards and by the exact character stream on the output port. An indexed load whose sum wraps past the top of the address space reads back a known program word.

// File: rtl/acc_pkg.sv
package acc_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_IMM_A = 4'd1,
    OP_IMM_X = 4'd2,
    OP_DIR   = 4'd3,
    OP_IND   = 4'd4,
    OP_IDX   = 4'd5,
    OP_ST    = 4'd6,
    OP_ADD   = 4'd7,
    OP_INC   = 4'd8,
    OP_DEC   = 4'd9,
    OP_CMP   = 4'd10,
    OP_BEQ   = 4'd11,
    OP_BNE   = 4'd12,
    OP_JMP   = 4'd13,
    OP_OUT   = 4'd14,
    OP_HALT  = 4'd15
  } op_e;

  typedef enum logic [3:0] {
    ST_FADDR,
    ST_FREAD,
    ST_FCAP,
    ST_FDEC,
    ST_EXEC,
    ST_RWAIT,
    ST_RCAP,
    ST_INDIR,
    ST_APPLY,
    ST_WRITE,
    ST_HALT
  } state_e;

  localparam int OPC_W = 4;

endpackage

// File: rtl/acc_decode.sv
module acc_decode #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic [DATA_W-1:0] instr,
  output acc_pkg::op_e      op,
  output logic              sel_ix,
  output logic [ADDR_W-1:0] operand,
  output logic              needs_read,
  output logic              is_indirect,
  output logic              is_store
);
  import acc_pkg::*;

  always_comb begin
    op          = op_e'(instr[DATA_W-1 -: OPC_W]);
    sel_ix      = instr[ADDR_W];
    operand     = instr[ADDR_W-1:0];
    needs_read  = (op == OP_DIR) || (op == OP_IND) || (op == OP_IDX) ||
                  (op == OP_ADD) || (op == OP_CMP);
    is_indirect = (op == OP_IND);
    is_store    = (op == OP_ST);
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  acc_pkg::op_e      op,
  input  logic              sel_ix,
  input  logic [ADDR_W-1:0] operand,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] ix,
  input  logic [DATA_W-1:0] mdr,
  output logic [DATA_W-1:0] acc_res,
  output logic [DATA_W-1:0] ix_res,
  output logic              eq
);
  import acc_pkg::*;

  localparam int PAD_W = DATA_W - ADDR_W;

  logic [DATA_W-1:0] opd_ext;
  logic [DATA_W-1:0] step_src;
  logic [DATA_W-1:0] step_up;
  logic [DATA_W-1:0] step_dn;

  always_comb begin
    opd_ext  = {{PAD_W{1'b0}}, operand};
    step_src = sel_ix ? ix : acc;
    step_up  = step_src + {{(DATA_W-1){1'b0}}, 1'b1};
    step_dn  = step_src - {{(DATA_W-1){1'b0}}, 1'b1};
    eq       = (acc == mdr);

    acc_res = acc;
    ix_res  = ix;
    unique case (op)
      OP_IMM_A: acc_res = opd_ext;
      OP_IMM_X: ix_res  = opd_ext;
      OP_DIR, OP_IND, OP_IDX: acc_res = mdr;
      OP_ADD:   acc_res = acc + mdr;
      OP_INC: begin
        if (sel_ix) ix_res = step_up;
        else        acc_res = step_up;
      end
      OP_DEC: begin
        if (sel_ix) ix_res = step_dn;
        else        acc_res = step_dn;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl (
  input  logic            clk,
  input  logic            rst,
  input  logic            needs_read,
  input  logic            is_indirect,
  input  logic            is_store,
  input  acc_pkg::op_e    op,
  output acc_pkg::state_e state
);
  import acc_pkg::*;

  state_e state_q, state_d;
  logic   ind_done;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FADDR: state_d = ST_FREAD;
      ST_FREAD: state_d = ST_FCAP;
      ST_FCAP:  state_d = ST_FDEC;
      ST_FDEC:  state_d = ST_EXEC;
      ST_EXEC: begin
        if (op == OP_HALT)  state_d = ST_HALT;
        else if (is_store)  state_d = ST_WRITE;
        else if (needs_read) state_d = ST_RWAIT;
        else                state_d = ST_FADDR;
      end
      ST_RWAIT: state_d = ST_RCAP;
      ST_RCAP:  state_d = (is_indirect && !ind_done) ? ST_INDIR : ST_APPLY;
      ST_INDIR: state_d = ST_RWAIT;
      ST_APPLY: state_d = ST_FADDR;
      ST_WRITE: state_d = ST_FADDR;
      ST_HALT:  state_d = ST_HALT;
      default:  state_d = ST_FADDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_FADDR;
      ind_done <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_EXEC)       ind_done <= 1'b0;
      else if (state_q == ST_INDIR) ind_done <= 1'b1;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter  int DATA_W = 16,
  parameter  int CHAR_W = 8,
  localparam int ADDR_W = DATA_W - 5
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [CHAR_W-1:0] out_char,
  output logic              out_valid,
  output logic              halted
);
  import acc_pkg::*;

  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] mdr;
  logic [DATA_W-1:0] cir;
  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] ix;
  logic              eq_flag;

  op_e               op;
  logic              sel_ix;
  logic [ADDR_W-1:0] operand;
  logic              needs_read;
  logic              is_indirect;
  logic              is_store;
  logic [DATA_W-1:0] acc_res;
  logic [DATA_W-1:0] ix_res;
  logic              eq;
  state_e            state;
  logic [ADDR_W-1:0] idx_addr;

  acc_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
    .instr(cir), .op(op), .sel_ix(sel_ix), .operand(operand),
    .needs_read(needs_read), .is_indirect(is_indirect), .is_store(is_store)
  );

  acc_alu #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_alu (
    .op(op), .sel_ix(sel_ix), .operand(operand), .acc(acc), .ix(ix),
    .mdr(mdr), .acc_res(acc_res), .ix_res(ix_res), .eq(eq)
  );

  acc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .needs_read(needs_read), .is_indirect(is_indirect),
    .is_store(is_store), .op(op), .state(state)
  );

  assign idx_addr = operand + ix[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc        <= '0;
      mar       <= '0;
      mdr       <= '0;
      cir       <= '0;
      acc       <= '0;
      ix        <= '0;
      eq_flag   <= 1'b0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      out_char  <= '0;
      out_valid <= 1'b0;
      halted    <= 1'b0;
    end else begin
      mem_we    <= 1'b0;
      out_valid <= 1'b0;
      unique case (state)
        ST_FADDR: mar <= pc;
        ST_FREAD: pc  <= pc + {{(ADDR_W-1){1'b0}}, 1'b1};
        ST_FCAP:  mdr <= mem_rdata;
        ST_FDEC:  cir <= mdr;
        ST_EXEC: begin
          if (!needs_read) begin
            acc <= acc_res;
            ix  <= ix_res;
          end else begin
            mar <= (op == OP_IDX) ? idx_addr : operand;
          end
          unique case (op)
            OP_ST: begin
              mar       <= operand;
              mem_wdata <= acc;
              mem_we    <= 1'b1;
            end
            OP_BEQ: if (eq_flag)  pc <= operand;
            OP_BNE: if (!eq_flag) pc <= operand;
            OP_JMP: pc <= operand;
            OP_OUT: begin
              out_char  <= acc[CHAR_W-1:0];
              out_valid <= 1'b1;
            end
            OP_HALT: halted <= 1'b1;
            default: ;
          endcase
        end
        ST_RCAP:  mdr <= mem_rdata;
        ST_INDIR: mar <= mdr[ADDR_W-1:0];
        ST_APPLY: begin
          if (op == OP_CMP) eq_flag <= eq;
          else              acc     <= acc_res;
        end
        default: ;
      endcase
    end
  end

  assign mem_addr = mar;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              out_valid,
  input logic              halted
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!halted && !mem_we && !out_valid && mem_addr == '0)); // R12

  AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we); // R6

  AST_OUT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R10

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted); // R11

  AST_HALT_NO_ACTIVITY: assert property (@(posedge clk) disable iff (rst)
    halted |=> (!mem_we && !out_valid)); // R11

  AST_HALT_ADDR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(mem_addr)); // R11

endmodule

bind acc_cpu acc_cpu_chk #(.ADDR_W(ADDR_W)) u_acc_cpu_chk (
  .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
  .out_valid(out_valid), .halted(halted)
);

// File: tb/tb_acc_cpu.sv
`timescale 1ns/1ps
module tb_acc_cpu;

  localparam int DATA_W = 16;
  localparam int ADDR_W = 11;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_we;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata = '0;
  logic [7:0]        out_char;
  logic              out_valid;
  logic              halted;

  int checks = 0;
  int errors = 0;
  logic [7:0] obuf [0:31];
  int outn   = 0;
  int wcount = 0;

  logic [DATA_W-1:0] mem [0:DEPTH-1];

  always #4 clk = ~clk;

  acc_cpu dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .out_char(out_char),
    .out_valid(out_valid), .halted(halted)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid && outn < 32) begin
        obuf[outn] = out_char;
        outn++;
      end
      if (mem_we) wcount++;
    end
  end

  function automatic logic [15:0] enc(input logic [3:0] op, input logic sel,
                                      input logic [10:0] opd);
    return {op, sel, opd};
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  endtask

  task automatic start_cpu();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    outn   = 0;
    wcount = 0;
    rst    = 1'b0;
  endtask

  task automatic wait_halt(input string req);
    int n = 0;
    while (!halted && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(req, {31'd0, halted}, 32'd1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R12 halted", {31'd0, halted}, 0);
    check("R12 mem_we", {31'd0, mem_we}, 0);
    check("R12 out_valid", {31'd0, out_valid}, 0);
    check("R12 mem_addr", {21'd0, mem_addr}, 0);
  endtask

  // Loads of every addressing mode, store, add with wrap
  task automatic t_loads();
    clear_mem();
    mem[0]  = enc(4'd3, 1'b0, 11'd100);
    mem[1]  = enc(4'd6, 1'b0, 11'd200);
    mem[2]  = enc(4'd4, 1'b0, 11'd101);
    mem[3]  = enc(4'd6, 1'b0, 11'd201);
    mem[4]  = enc(4'd2, 1'b0, 11'd3);
    mem[5]  = enc(4'd5, 1'b0, 11'd110);
    mem[6]  = enc(4'd6, 1'b0, 11'd202);
    mem[7]  = enc(4'd1, 1'b0, 11'h7FF);
    mem[8]  = enc(4'd6, 1'b0, 11'd203);
    mem[9]  = enc(4'd7, 1'b0, 11'd100);
    mem[10] = enc(4'd6, 1'b0, 11'd204);
    mem[11] = enc(4'd7, 1'b0, 11'd105);
    mem[12] = enc(4'd6, 1'b0, 11'd205);
    mem[13] = enc(4'd15, 1'b0, 11'd0);
    mem[100] = 16'h1234;
    mem[101] = 16'd102;
    mem[102] = 16'hBEEF;
    mem[105] = 16'hFFFF;
    mem[112] = 16'h0707;
    mem[113] = 16'h0A0B;
    mem[114] = 16'h0C0C;
    start_cpu();
    wait_halt("R11 loads program halts");
    check("R3 direct load",        mem[200], 16'h1234);
    check("R4 indirect load",      mem[201], 16'hBEEF);
    check("R5 indexed load",       mem[202], 16'h0A0B);
    check("R2 immediate to ACC",   mem[203], 16'h07FF);
    check("R6 add",                mem[204], 16'h1A33);
    check("R8 add wraps",          mem[205], 16'h1A32);
    check("R6 one strobe per store", wcount, 6);
  endtask

  // INC/DEC on either register, wrap, indexed address wrap
  task automatic t_incdec();
    clear_mem();
    mem[0]  = enc(4'd1, 1'b0, 11'd0);
    mem[1]  = enc(4'd9, 1'b0, 11'd0);
    mem[2]  = enc(4'd6, 1'b0, 11'd300);
    mem[3]  = enc(4'd8, 1'b0, 11'd0);
    mem[4]  = enc(4'd6, 1'b0, 11'd301);
    mem[5]  = enc(4'd2, 1'b0, 11'd9);
    mem[6]  = enc(4'd8, 1'b1, 11'd0);
    mem[7]  = enc(4'd8, 1'b1, 11'd0);
    mem[8]  = enc(4'd9, 1'b1, 11'd0);
    mem[9]  = enc(4'd6, 1'b0, 11'd303);
    mem[10] = enc(4'd5, 1'b0, 11'd400);
    mem[11] = enc(4'd6, 1'b0, 11'd302);
    mem[12] = enc(4'd2, 1'b0, 11'd0);
    mem[13] = enc(4'd9, 1'b1, 11'd0);
    mem[14] = enc(4'd5, 1'b0, 11'd5);
    mem[15] = enc(4'd6, 1'b0, 11'd304);
    mem[16] = enc(4'd15, 1'b0, 11'd0);
    mem[409] = 16'h1111;
    mem[410] = 16'h5555;
    mem[411] = 16'h2222;
    start_cpu();
    wait_halt("R11 inc/dec program halts");
    check("R8 DEC ACC wraps to all ones", mem[300], 16'hFFFF);
    check("R8 INC ACC wraps to zero",     mem[301], 16'h0000);
    check("R7 IX ops leave ACC",          mem[303], 16'h0000);
    check("R7 IX stepped to 10",          mem[302], 16'h5555);
    check("R5 index sum truncates to 11 bits", mem[304],
          enc(4'd6, 1'b0, 11'd301));
  endtask

  // Fetch timing, compare/branch, output, NOP, halt
  task automatic t_branch_out();
    clear_mem();
    mem[0]  = enc(4'd1, 1'b0, 11'h41);
    mem[1]  = enc(4'd14, 1'b0, 11'd0);
    mem[2]  = enc(4'd8, 1'b0, 11'd0);
    mem[3]  = enc(4'd10, 1'b0, 11'd500);
    mem[4]  = enc(4'd12, 1'b0, 11'd1);
    mem[5]  = enc(4'd1, 1'b0, 11'h5A);
    mem[6]  = enc(4'd10, 1'b0, 11'd501);
    mem[7]  = enc(4'd11, 1'b0, 11'd9);
    mem[8]  = enc(4'd14, 1'b0, 11'd0);
    mem[9]  = enc(4'd13, 1'b0, 11'd11);
    mem[10] = enc(4'd14, 1'b0, 11'd0);
    mem[11] = enc(4'd1, 1'b0, 11'h21);
    mem[12] = enc(4'd0, 1'b1, 11'h7FF);
    mem[13] = enc(4'd14, 1'b0, 11'd0);
    mem[14] = enc(4'd15, 1'b0, 11'd0);
    mem[15] = enc(4'd14, 1'b0, 11'd0);
    mem[16] = enc(4'd6, 1'b0, 11'd600);
    mem[500] = 16'h0044;
    mem[501] = 16'h005A;
    start_cpu();
    begin
      logic bad = 1'b0;
      for (int i = 1; i <= 5; i++) begin
        @(negedge clk);
        if (mem_addr !== 11'd0) bad = 1'b1;
      end
      check("R1 address 0 held for five edges", {31'd0, bad}, 0);
      @(negedge clk);
      check("R1 next fetch address after sixth edge", {21'd0, mem_addr}, 1);
    end
    wait_halt("R11 branch program halts");
    check("R10 output count", outn, 4);
    check("R10 char 0", {24'd0, obuf[0]}, 32'h41);
    check("R9 BNE loop char 1", {24'd0, obuf[1]}, 32'h42);
    check("R9 BNE loop char 2", {24'd0, obuf[2]}, 32'h43);
    check("R13 NOP keeps ACC", {24'd0, obuf[3]}, 32'h21);
    check("R13 no memory writes", wcount, 0);
    begin
      logic [ADDR_W-1:0] a0 = mem_addr;
      logic bad = 1'b0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (!halted || mem_we || out_valid || mem_addr !== a0) bad = 1'b1;
      end
      check("R11 parked after halt", {31'd0, bad}, 0);
      check("R11 nothing past halt executed", outn, 4);
      check("R11 no write past halt", mem[600], 16'h0000);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_loads();
    t_incdec();
    t_branch_out();
    t_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule